// File: doc/BRIEF.md
# Bus Cycle Wait-State Inserter

This block stretches bus cycles of an 8-bit processor by holding a wait request for a programmed number of clocks. It watches the cycle-type strobes the processor drives (memory request, I/O request, opcode fetch, interrupt acknowledge) together with a select line that marks an access to the onboard ROM. From these it decides which class the new cycle belongs to, picks that class's wait count, and drives the wait output for exactly that many clocks.

There are three independent counts of 0 to 8 states: one for onboard ROM, one for I/O, and one for memory. The memory count is steered by a two-bit mode. It can cover interrupt-acknowledge cycles only, opcode fetches only (the lighter setting, because fetches have the tightest access time), or every memory cycle (the fallback for slow memory). A count of zero leaves the cycle untouched. The counts are sampled once, when a cycle begins.

Top module: `bus_wait_gen`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) clears the counter, so wait_o is low after that edge, even in the middle of a wait.
- R2: A cycle whose selected count is 0 never raises wait_o.
- R3: A cycle starts at the first clock edge where any of mem_req, io_req or int_ack is high after an edge where all three were low. For a selected count N, wait_o is high from that edge for exactly N clocks, then stays low until the cycle ends.
- R4: A memory cycle with rom_sel high is a ROM cycle. It uses rom_waits, and mem_waits is not applied to it in any mode.
- R5: A cycle with io_req high uses io_waits.
- R6: mem_mode selects which non-ROM cycles use mem_waits: 2'b00 none; 2'b01 cycles with int_ack high; 2'b10 memory cycles with fetch high; 2'b11 all memory cycles.
- R7: When a cycle falls into more than one applicable class (for example int_ack with io_req under mode 2'b01), the largest of their counts is used.
- R8: The count is loaded only at a cycle start. Changes to the count inputs during a cycle have no effect, and a cycle never re-triggers while its strobes stay high.
- R9: If the cycle ends (all three strobes low at an edge) before the count runs out, wait_o is low after that edge.
- R10: A count input above 8 is treated as 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_req | input | 1 | Memory cycle in progress (active high) |
| io_req | input | 1 | I/O cycle in progress (active high) |
| fetch | input | 1 | Opcode fetch qualifier |
| int_ack | input | 1 | Interrupt acknowledge cycle in progress |
| rom_sel | input | 1 | Current memory access targets the onboard ROM |
| rom_waits | input | 4 | Wait count for ROM cycles |
| mem_waits | input | 4 | Wait count for memory cycles selected by mem_mode |
| io_waits | input | 4 | Wait count for I/O cycles |
| mem_mode | input | 2 | Memory wait mode (see R6) |
| wait_o | output | 1 | Wait request to the processor, active high |

## Verification
The bench goes after the off-by-one in the stretch length: a design that loads one clock late, or counts N+1, leaves wait_o high one sample too long at the end of a cycle. It changes the counts in the middle of a cycle, and a design that reloads mid-cycle would then stretch the cycle to the new value. It drives ROM cycles with a large memory count set in all-memory mode, where a missing ROM priority gives the memory count, and it drives interrupt acknowledge together with I/O, where taking one class instead of the maximum gives a short wait. Short cycles, counts above 8 and a reset in mid-wait cover a counter that fails to clear, fails to saturate, or wraps.

// File: rtl/cwg_pkg.sv
// Shared types for the bus wait-state inserter.
// Assumes: the mode code values are decoded by the classifier exactly as listed.
package cwg_pkg;

    typedef enum logic [1:0] {
        MODE_OFF    = 2'b00,
        MODE_INTA   = 2'b01,
        MODE_FETCH  = 2'b10,
        MODE_ALLMEM = 2'b11
    } mem_mode_e;

    typedef struct packed {
        logic rom;
        logic inta;
        logic fetch;
        logic io;
        logic mem;
    } cyc_kind_t;

    localparam int NUM_CLASSES = 3;
    localparam int CLS_ROM = 0;
    localparam int CLS_MEM = 1;
    localparam int CLS_IO  = 2;

endpackage

// File: rtl/cwg_classify.sv
// Cycle classifier: works out which wait classes apply to the present
// strobes and returns the largest clamped count among them.
// Assumes: the strobes are stable while the start edge samples them.
// ROM cycles suppress the memory class; other overlaps take the maximum.
module cwg_classify
    import cwg_pkg::*;
#(
    parameter int MAX_WAITS = 8,
    localparam int CW = $clog2(MAX_WAITS + 1)
) (
    input  cyc_kind_t       kind,
    input  logic [1:0]      mode,
    input  logic [CW-1:0]   rom_cnt,
    input  logic [CW-1:0]   mem_cnt,
    input  logic [CW-1:0]   io_cnt,
    output logic [CW-1:0]   sel_cnt
);

    localparam logic [CW-1:0] LIM = CW'(MAX_WAITS);

    logic [CW-1:0] raw [NUM_CLASSES];
    logic [CW-1:0] eff [NUM_CLASSES];
    logic          hit [NUM_CLASSES];
    logic          rom_cyc;
    logic          mem_by_mode;

    assign raw[CLS_ROM] = rom_cnt;
    assign raw[CLS_MEM] = mem_cnt;
    assign raw[CLS_IO]  = io_cnt;

    // Saturate every class count at the largest legal wait number.
    for (genvar g = 0; g < NUM_CLASSES; g++) begin : g_clamp
        assign eff[g] = (raw[g] > LIM) ? LIM : raw[g];
    end

    assign rom_cyc = kind.mem & kind.rom;

    // Decide whether the memory count covers this cycle under the mode.
    always_comb begin
        case (mem_mode_e'(mode))
            MODE_INTA:   mem_by_mode = kind.inta;
            MODE_FETCH:  mem_by_mode = kind.mem & kind.fetch;
            MODE_ALLMEM: mem_by_mode = kind.mem;
            default:     mem_by_mode = 1'b0;
        endcase
    end

    assign hit[CLS_ROM] = rom_cyc;
    assign hit[CLS_MEM] = mem_by_mode & ~rom_cyc;
    assign hit[CLS_IO]  = kind.io;

    // Pick the largest count among the classes that apply.
    always_comb begin
        sel_cnt = '0;
        for (int i = 0; i < NUM_CLASSES; i++) begin
            if (hit[i] && (eff[i] > sel_cnt)) begin
                sel_cnt = eff[i];
            end
        end
    end

endmodule

// File: rtl/cwg_start_det.sv
// Cycle start detector: flags the clock where any cycle strobe is high
// after a clock where none was.
// Assumes: strobes are synchronous to clk.
module cwg_start_det (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic start
);

    logic active_q;

    // Remember whether a cycle was already in progress at the last edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
        end else begin
            active_q <= active;
        end
    end

    assign start = active & ~active_q;

endmodule

// File: rtl/cwg_counter.sv
// Wait counter: loads the selected count at a cycle start, counts down
// while the cycle lasts and clears when the cycle ends or on reset.
// Assumes: load_val is already clamped to MAX_WAITS.
module cwg_counter #(
    parameter int MAX_WAITS = 8,
    localparam int CW = $clog2(MAX_WAITS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          active,
    input  logic [CW-1:0] load_val,
    output logic          stall
);

    localparam logic [CW-1:0] LIM = CW'(MAX_WAITS);

    logic [CW-1:0] cnt;

    // Load at a start, clear at cycle end, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= load_val;
        end else if (!active) begin
            cnt <= '0;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign stall = (cnt != '0);

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIM); // R10
    AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (cnt <= $past(cnt))); // R8
    AST_END_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !stall); // R9
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> !stall); // R1

endmodule

// File: rtl/bus_wait_gen.sv
// Bus wait-state inserter top: classifies each new bus cycle, loads the
// matching wait count and holds wait_o for that many clocks.
// Assumes: one processor clock domain; strobes active high.
module bus_wait_gen
    import cwg_pkg::*;
#(
    parameter int MAX_WAITS = 8,
    localparam int CW = $clog2(MAX_WAITS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mem_req,
    input  logic          io_req,
    input  logic          fetch,
    input  logic          int_ack,
    input  logic          rom_sel,
    input  logic [CW-1:0] rom_waits,
    input  logic [CW-1:0] mem_waits,
    input  logic [CW-1:0] io_waits,
    input  logic [1:0]    mem_mode,
    output logic          wait_o
);

    localparam logic [CW-1:0] LIM = CW'(MAX_WAITS);

    cyc_kind_t     kind;
    logic          active;
    logic          start;
    logic [CW-1:0] sel_cnt;

    assign kind   = '{rom: rom_sel, inta: int_ack, fetch: fetch, io: io_req, mem: mem_req};
    assign active = mem_req | io_req | int_ack;

    cwg_classify #(.MAX_WAITS(MAX_WAITS)) u_classify (
        .kind    (kind),
        .mode    (mem_mode),
        .rom_cnt (rom_waits),
        .mem_cnt (mem_waits),
        .io_cnt  (io_waits),
        .sel_cnt (sel_cnt)
    );

    cwg_start_det u_start (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (active),
        .start  (start)
    );

    cwg_counter #(.MAX_WAITS(MAX_WAITS)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .active   (active),
        .load_val (sel_cnt),
        .stall    (wait_o)
    );

    AST_ZERO_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (start && sel_cnt == '0) |=> !wait_o); // R2
    AST_START_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (start && sel_cnt != '0) |=> wait_o); // R3
    AST_ROM_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && rom_sel && !io_req) |->
            (sel_cnt == ((rom_waits > LIM) ? LIM : rom_waits))); // R4

endmodule

// File: tb/tb_bus_wait_gen.sv
module tb_bus_wait_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mem_req = 1'b0, io_req = 1'b0, fetch = 1'b0, int_ack = 1'b0, rom_sel = 1'b0;
    logic [3:0] rom_waits = '0, mem_waits = '0, io_waits = '0;
    logic [1:0] mem_mode = 2'b00;
    logic       wait_o;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    bus_wait_gen dut (
        .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .io_req(io_req),
        .fetch(fetch), .int_ack(int_ack), .rom_sel(rom_sel),
        .rom_waits(rom_waits), .mem_waits(mem_waits), .io_waits(io_waits),
        .mem_mode(mem_mode), .wait_o(wait_o)
    );

    function automatic int clampw(input logic [3:0] v);
        return (v > 4'd8) ? 8 : int'(v);
    endfunction

    // Expected wait count from the requirements R4..R7, R10.
    function automatic int exp_waits(input logic m, input logic io, input logic f,
                                     input logic ia, input logic r,
                                     input logic [3:0] rc, input logic [3:0] mc,
                                     input logic [3:0] ic, input logic [1:0] md);
        int  best = 0;
        logic rom_cyc = m & r;
        logic mem_hit;
        case (md)
            2'b01:   mem_hit = ia;
            2'b10:   mem_hit = m & f;
            2'b11:   mem_hit = m;
            default: mem_hit = 1'b0;
        endcase
        if (rom_cyc && clampw(rc) > best) best = clampw(rc);
        if (mem_hit && !rom_cyc && clampw(mc) > best) best = clampw(mc);
        if (io && clampw(ic) > best) best = clampw(ic);
        return best;
    endfunction

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: wait_o=%0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic idle_inputs();
        mem_req = 0; io_req = 0; fetch = 0; int_ack = 0; rom_sel = 0;
    endtask

    // Run one bus cycle of len clocks and check wait_o on every clock.
    task automatic run_cycle(input logic m, input logic io, input logic f,
                             input logic ia, input logic r,
                             input logic [3:0] rc, input logic [3:0] mc,
                             input logic [3:0] ic, input logic [1:0] md,
                             input int len, input bit change_mid, input string tag);
        int n;
        @(negedge clk);
        rom_waits = rc; mem_waits = mc; io_waits = ic; mem_mode = md;
        mem_req = m; io_req = io; fetch = f; int_ack = ia; rom_sel = r;
        n = exp_waits(m, io, f, ia, r, rc, mc, ic, md);
        for (int i = 1; i <= len; i++) begin
            @(negedge clk);
            check(wait_o, (i <= n), tag);
            if (i == 1 && change_mid) begin
                rom_waits = 4'(8 - clampw(rc) + 1);
                mem_waits = 4'd8; io_waits = 4'd15;
                mem_mode = ~md;
            end
        end
        idle_inputs();
        @(negedge clk);
        check(wait_o, 1'b0, (len < n) ? "R9 early end" : tag);
    endtask

    initial begin
        #(8 * 150000);
        fails++; checks++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(wait_o, 1'b0, "R1 reset state");
        rst_n = 1;
        @(negedge clk);
        check(wait_o, 1'b0, "R1 idle after reset");

        run_cycle(1,0,0,0,0, 4'd0, 4'd0, 4'd0, 2'b11, 4, 0, "R2 zero count");
        run_cycle(1,0,0,0,0, 4'd0, 4'd3, 4'd0, 2'b11, 6, 0, "R3 mem N=3");
        run_cycle(1,0,1,0,0, 4'd0, 4'd8, 4'd0, 2'b11, 10, 0, "R3 mem N=8");
        run_cycle(1,0,0,0,1, 4'd2, 4'd7, 4'd0, 2'b11, 9, 0, "R4 rom over mem");
        run_cycle(1,0,1,0,1, 4'd0, 4'd6, 4'd0, 2'b10, 8, 0, "R4 rom zero");
        run_cycle(0,1,0,0,0, 4'd0, 4'd0, 4'd5, 2'b11, 7, 0, "R5 io");
        run_cycle(1,0,1,0,0, 4'd0, 4'd4, 4'd0, 2'b10, 6, 0, "R6 fetch mode fetch");
        run_cycle(1,0,0,0,0, 4'd0, 4'd4, 4'd0, 2'b10, 6, 0, "R6 fetch mode read");
        run_cycle(0,0,1,1,0, 4'd0, 4'd4, 4'd0, 2'b01, 6, 0, "R6 inta mode");
        run_cycle(1,0,1,0,0, 4'd0, 4'd5, 4'd0, 2'b00, 6, 0, "R6 mode off");
        run_cycle(1,0,1,0,0, 4'd0, 4'd5, 4'd0, 2'b01, 6, 0, "R6 inta mode on fetch");
        run_cycle(0,1,1,1,0, 4'd0, 4'd6, 4'd1, 2'b01, 8, 0, "R7 inta+io mem larger");
        run_cycle(0,1,1,1,0, 4'd0, 4'd2, 4'd7, 2'b01, 9, 0, "R7 inta+io io larger");
        run_cycle(1,0,0,0,0, 4'd0, 4'd3, 4'd0, 2'b11, 7, 1, "R8 mid-cycle change");
        run_cycle(1,0,0,0,0, 4'd0, 4'd8, 4'd0, 2'b11, 3, 0, "R9 short cycle");
        run_cycle(0,1,0,0,0, 4'd0, 4'd0, 4'd15, 2'b11, 11, 0, "R10 clamp io");
        run_cycle(1,0,0,0,1, 4'd12, 4'd0, 4'd0, 2'b11, 11, 0, "R10 clamp rom");

        // R1: reset in the middle of a wait.
        @(negedge clk);
        mem_waits = 4'd8; mem_mode = 2'b11; mem_req = 1;
        @(negedge clk);
        check(wait_o, 1'b1, "R3 before reset");
        rst_n = 0; idle_inputs();
        @(negedge clk);
        check(wait_o, 1'b0, "R1 reset mid-wait");
        rst_n = 1;
        @(negedge clk);

        // Random cycles, mostly long enough to see the whole stretch.
        for (int k = 0; k < 80; k++) begin
            logic [4:0] b = 5'($urandom);
            logic [3:0] rc = 4'($urandom), mc = 4'($urandom), ic = 4'($urandom);
            logic [1:0] md = 2'($urandom);
            int len = 1 + int'($urandom % 12);
            if (b[0] == 0 && b[1] == 0 && b[3] == 0) b[0] = 1;
            run_cycle(b[0], b[1], b[2], b[3], b[4], rc, mc, ic, md, len,
                      ($urandom % 4) == 0, "R3 random cycle");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule